// File: doc/BRIEF.md
# Fetch Group Extractor with Next-PC

This block sits between a single-thread instruction line buffer and the decode stage. Each cycle a valid line is offered, it carves a group of fixed four-byte instructions out of that line, starting at the word that holds the thread's program counter. It attaches a predicted next-PC to each one, using a per-word control flag, a taken flag and a target from the branch predictor, and tags each with a fresh sequence number. The group is written into a registered slot array for decode.

A group stops at the end of the line, at the slot-count limit, after an instruction whose flow is not sequential (a taken branch, or a thread whose next-PC is not PC+4), or after a quiesce instruction. When the group is done, the thread's PC and next-PC move to the values computed for the last emitted instruction. A translation fault replaces the group with one no-op that carries the fault and parks the thread. A redirect reloads PC and next-PC and releases a parked thread.

Top module: `fetch_group_extract`

## Requirements
- R1: After reset, no slot is valid, `wrote_o` is 0, all three counts are 0, both pending flags are 0, `pc_o` equals `RESET_PC` and `npc_o` equals `RESET_PC+4`.
- R2: The first emitted slot takes line word `pc[OFF_W+1:2]`, with `OFF_W = log2(LINE_WORDS)`. Slot k takes the next word in order and carries its own PC. Valid slots always form a prefix starting at slot 0. No word past the last word of the line is emitted. Slot k occupies bits `[k*W +: W]` of each flat slot port.
- R3: At most `WIDTH` instructions are emitted per cycle.
- R4: A word whose control flag is 0 gets the thread's running next-PC as its predicted next-PC, and its taken flag is ignored. If that next-PC is not its PC+4, the group ends after it.
- R5: A control word gets its predicted target as next-PC when its taken flag is 1, and PC+4 otherwise. The next-next-PC is always next-PC+4. A taken branch whose target equals PC+4 does not end the group.
- R6: The group ends after any word whose computed next-PC differs from the running next-PC it came in with.
- R7: The sequence number of slot k equals the base number plus k. The base number grows by the number of slots emitted, across cycles and across redirects.
- R8: A word with its quiesce flag set is emitted and ends the group. It sets `quiesce_pend_o`, and no slot is emitted until a redirect.
- R9: A fault with a valid line emits only slot 0, holding `NOP_WORD`, the thread's PC and next-PC and `slot_fault_o[0]=1`. It sets `trap_pend_o`, leaves PC unchanged and blocks fetch until a redirect.
- R10: After a fault-free group, `pc_o` and `npc_o` hold the last emitted slot's next-PC and that value plus 4.
- R11: In the cycle a group is presented, `wrote_o`, `emit_cnt_o`, `br_cnt_o` and `taken_cnt_o` give, for that group: whether any slot was emitted, the number emitted, the number of emitted control words, and the number of emitted control words predicted taken. A fault slot counts as one emitted and no branch.
- R12: `redirect_i` loads PC and next-PC, clears both pending flags and suppresses emission in that cycle. All slot outputs appear one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Load a new PC and next-PC |
| redirect_pc_i | input | PC_W | New PC |
| redirect_npc_i | input | PC_W | New next-PC |
| line_valid_i | input | 1 | Line holding the PC is present |
| fault_i | input | 1 | Translation fault for this fetch |
| line_data_i | input | LINE_WORDS*INST_W | Line words, word w at [w*INST_W +: INST_W] |
| ctrl_flag_i | input | LINE_WORDS | Per-word control instruction flag |
| quiesce_flag_i | input | LINE_WORDS | Per-word quiesce instruction flag |
| pred_taken_i | input | LINE_WORDS | Per-word predicted-taken flag |
| pred_target_i | input | LINE_WORDS*PC_W | Per-word predicted target |
| slot_valid_o | output | WIDTH | Slot holds an instruction |
| slot_inst_o | output | WIDTH*INST_W | Instruction words |
| slot_pc_o | output | WIDTH*PC_W | Instruction PCs |
| slot_npc_o | output | WIDTH*PC_W | Predicted next-PCs |
| slot_seq_o | output | WIDTH*SEQ_W | Sequence numbers |
| slot_fault_o | output | WIDTH | Fault-carrying no-op marker |
| wrote_o | output | 1 | At least one slot emitted |
| emit_cnt_o | output | CNT_W | Slots emitted |
| br_cnt_o | output | CNT_W | Control words emitted |
| taken_cnt_o | output | CNT_W | Predicted-taken control words emitted |
| pc_o | output | PC_W | Thread PC |
| npc_o | output | PC_W | Thread next-PC |
| trap_pend_o | output | 1 | Thread waiting on a trap |
| quiesce_pend_o | output | 1 | Thread quiesced |

## Verification
The assertions check on every cycle that the valid slots form a prefix no wider than `WIDTH`, that the counts agree with the valid vector, that sequence numbers continue from one emitting cycle to the next, that a fault slot stands alone with the trap flag raised, and that a parked thread emits nothing until redirected. The scenarios show what no local property can: which line word each slot picks for a given PC offset, the predicted next-PC for control and non-control words, where each stop rule cuts the group, and the PC written back afterwards. Each scenario is compared cycle by cycle against a behavioural model.

// File: rtl/fge_pkg.sv
package fge_pkg;
  localparam int unsigned INST_BYTES = 4;

  typedef enum logic [1:0] {
    TH_RUN     = 2'd0,
    TH_QUIESCE = 2'd1,
    TH_TRAP    = 2'd2
  } th_mode_e;
endpackage

// File: rtl/fge_nextpc.sv
module fge_nextpc #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  input  logic            ctrl_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] nxt_pc_o,
  output logic [PC_W-1:0] nxt_npc_o,
  output logic            disc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(fge_pkg::INST_BYTES);

  logic [PC_W-1:0] seq_pc;

  assign seq_pc    = pc_i + STEP;
  assign nxt_pc_o  = ctrl_i ? (taken_i ? target_i : seq_pc) : npc_i;
  assign nxt_npc_o = nxt_pc_o + STEP;
  // flow leaves the straight line either before or after this word
  assign disc_o    = (seq_pc != npc_i) || (nxt_pc_o != npc_i);
endmodule

// File: rtl/fge_chain.sv
module fge_chain #(
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_W     = 32
) (
  input  logic [PC_W-1:0]              pc_i,
  input  logic [PC_W-1:0]              npc_i,
  input  logic [LINE_WORDS*INST_W-1:0] line_data_i,
  input  logic [LINE_WORDS-1:0]        ctrl_i,
  input  logic [LINE_WORDS-1:0]        quiesce_i,
  input  logic [LINE_WORDS-1:0]        taken_i,
  input  logic [LINE_WORDS*PC_W-1:0]   target_i,
  output logic [WIDTH-1:0]             emit_o,
  output logic [WIDTH*INST_W-1:0]      inst_o,
  output logic [WIDTH*PC_W-1:0]        pc_o,
  output logic [WIDTH*PC_W-1:0]        npc_o,
  output logic [WIDTH-1:0]             br_o,
  output logic [WIDTH-1:0]             tk_o,
  output logic                         quiesce_hit_o,
  output logic [PC_W-1:0]              last_pc_o,
  output logic [PC_W-1:0]              last_npc_o
);
  localparam int unsigned OFF_W = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W = $clog2(LINE_WORDS + WIDTH);

  logic [OFF_W-1:0] start;
  logic [WIDTH-1:0] q_emit;

  assign start = pc_i[OFF_W+1:2];

  for (genvar k = 0; k < WIDTH; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] w;
    logic             in_line, alive, disc, stop, is_ctrl, is_q, is_tk;
    logic [PC_W-1:0]  cur_pc, cur_npc, nxt_pc, nxt_npc, fin_pc, fin_npc;

    assign idx     = IDX_W'(start) + IDX_W'(k);
    assign in_line = idx < IDX_W'(LINE_WORDS);
    assign w       = idx[OFF_W-1:0];
    assign is_ctrl = ctrl_i[w];
    assign is_q    = quiesce_i[w];
    assign is_tk   = taken_i[w];

    if (k == 0) begin : g_head
      assign cur_pc  = pc_i;
      assign cur_npc = npc_i;
      assign alive   = in_line;
      assign fin_pc  = nxt_pc;
      assign fin_npc = nxt_npc;
    end else begin : g_tail
      assign cur_pc  = g_slot[k-1].nxt_pc;
      assign cur_npc = g_slot[k-1].nxt_npc;
      assign alive   = g_slot[k-1].alive && !g_slot[k-1].stop && in_line;
      assign fin_pc  = alive ? nxt_pc  : g_slot[k-1].fin_pc;
      assign fin_npc = alive ? nxt_npc : g_slot[k-1].fin_npc;
    end

    fge_nextpc #(.PC_W(PC_W)) u_npc (
      .pc_i     (cur_pc),
      .npc_i    (cur_npc),
      .ctrl_i   (is_ctrl),
      .taken_i  (is_tk),
      .target_i (target_i[w*PC_W +: PC_W]),
      .nxt_pc_o (nxt_pc),
      .nxt_npc_o(nxt_npc),
      .disc_o   (disc)
    );

    assign stop                        = is_q || disc;
    assign emit_o[k]                   = alive;
    assign q_emit[k]                   = alive && is_q;
    assign br_o[k]                     = alive && is_ctrl;
    assign tk_o[k]                     = alive && is_ctrl && is_tk;
    assign inst_o[k*INST_W +: INST_W]  = line_data_i[w*INST_W +: INST_W];
    assign pc_o[k*PC_W +: PC_W]        = cur_pc;
    assign npc_o[k*PC_W +: PC_W]       = nxt_pc;
  end

  assign quiesce_hit_o = |q_emit;
  assign last_pc_o     = g_slot[WIDTH-1].fin_pc;
  assign last_npc_o    = g_slot[WIDTH-1].fin_npc;
endmodule

// File: rtl/fge_thread_state.sv
module fge_thread_state #(
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     SEQ_W    = 16,
  parameter int unsigned     CNT_W    = 3,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redirect_i,
  input  logic [PC_W-1:0]  redirect_pc_i,
  input  logic [PC_W-1:0]  redirect_npc_i,
  input  logic             line_valid_i,
  input  logic             fault_i,
  input  logic             quiesce_hit_i,
  input  logic [PC_W-1:0]  last_pc_i,
  input  logic [PC_W-1:0]  last_npc_i,
  input  logic [CNT_W-1:0] seq_add_i,
  output logic             go_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             trap_o,
  output logic             quiesce_o
);
  import fge_pkg::*;

  th_mode_e        mode_q;
  logic [PC_W-1:0] pc_q, npc_q;
  logic [SEQ_W-1:0] seq_q;

  assign go_o = line_valid_i && (mode_q == TH_RUN) && !redirect_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TH_RUN;
      pc_q   <= RESET_PC;
      npc_q  <= RESET_PC + PC_W'(INST_BYTES);
      seq_q  <= '0;
    end else if (redirect_i) begin
      mode_q <= TH_RUN;
      pc_q   <= redirect_pc_i;
      npc_q  <= redirect_npc_i;
    end else if (go_o) begin
      seq_q <= seq_q + SEQ_W'(seq_add_i);
      if (fault_i) begin
        mode_q <= TH_TRAP;
      end else begin
        pc_q  <= last_pc_i;
        npc_q <= last_npc_i;
        if (quiesce_hit_i) mode_q <= TH_QUIESCE;
      end
    end
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign seq_o     = seq_q;
  assign trap_o    = mode_q == TH_TRAP;
  assign quiesce_o = mode_q == TH_QUIESCE;

  assert_trap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TH_TRAP && !redirect_i) |=> (mode_q == TH_TRAP && pc_q == $past(pc_q)));

  assert_redirect_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (mode_q == TH_RUN && pc_q == $past(redirect_pc_i)));
endmodule

// File: rtl/fetch_group_extract.sv
module fetch_group_extract #(
  parameter int unsigned       WIDTH      = 4,
  parameter int unsigned       LINE_WORDS = 8,
  parameter int unsigned       PC_W       = 32,
  parameter int unsigned       INST_W     = 32,
  parameter int unsigned       SEQ_W      = 16,
  parameter logic [PC_W-1:0]   RESET_PC   = 32'h0000_1000,
  parameter logic [INST_W-1:0] NOP_WORD   = 32'h0000_0013,
  localparam int unsigned      CNT_W      = $clog2(WIDTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         redirect_i,
  input  logic [PC_W-1:0]              redirect_pc_i,
  input  logic [PC_W-1:0]              redirect_npc_i,
  input  logic                         line_valid_i,
  input  logic                         fault_i,
  input  logic [LINE_WORDS*INST_W-1:0] line_data_i,
  input  logic [LINE_WORDS-1:0]        ctrl_flag_i,
  input  logic [LINE_WORDS-1:0]        quiesce_flag_i,
  input  logic [LINE_WORDS-1:0]        pred_taken_i,
  input  logic [LINE_WORDS*PC_W-1:0]   pred_target_i,
  output logic [WIDTH-1:0]             slot_valid_o,
  output logic [WIDTH*INST_W-1:0]      slot_inst_o,
  output logic [WIDTH*PC_W-1:0]        slot_pc_o,
  output logic [WIDTH*PC_W-1:0]        slot_npc_o,
  output logic [WIDTH*SEQ_W-1:0]       slot_seq_o,
  output logic [WIDTH-1:0]             slot_fault_o,
  output logic                         wrote_o,
  output logic [CNT_W-1:0]             emit_cnt_o,
  output logic [CNT_W-1:0]             br_cnt_o,
  output logic [CNT_W-1:0]             taken_cnt_o,
  output logic [PC_W-1:0]              pc_o,
  output logic [PC_W-1:0]              npc_o,
  output logic                         trap_pend_o,
  output logic                         quiesce_pend_o
);
  logic                    go, q_hit;
  logic [PC_W-1:0]         th_pc, th_npc, last_pc, last_npc;
  logic [SEQ_W-1:0]        th_seq;
  logic [WIDTH-1:0]        ch_emit, ch_br, ch_tk;
  logic [WIDTH*INST_W-1:0] ch_inst;
  logic [WIDTH*PC_W-1:0]   ch_pc, ch_npc;

  logic [WIDTH-1:0]        nv_valid, nv_fault;
  logic [WIDTH*INST_W-1:0] nv_inst;
  logic [WIDTH*PC_W-1:0]   nv_pc, nv_npc;
  logic [WIDTH*SEQ_W-1:0]  nv_seq;
  logic [CNT_W-1:0]        nv_cnt, nv_br, nv_tk;

  fge_chain #(
    .WIDTH(WIDTH), .LINE_WORDS(LINE_WORDS), .PC_W(PC_W), .INST_W(INST_W)
  ) u_chain (
    .pc_i         (th_pc),
    .npc_i        (th_npc),
    .line_data_i  (line_data_i),
    .ctrl_i       (ctrl_flag_i),
    .quiesce_i    (quiesce_flag_i),
    .taken_i      (pred_taken_i),
    .target_i     (pred_target_i),
    .emit_o       (ch_emit),
    .inst_o       (ch_inst),
    .pc_o         (ch_pc),
    .npc_o        (ch_npc),
    .br_o         (ch_br),
    .tk_o         (ch_tk),
    .quiesce_hit_o(q_hit),
    .last_pc_o    (last_pc),
    .last_npc_o   (last_npc)
  );

  fge_thread_state #(
    .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
  ) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .redirect_npc_i(redirect_npc_i),
    .line_valid_i  (line_valid_i),
    .fault_i       (fault_i),
    .quiesce_hit_i (q_hit),
    .last_pc_i     (last_pc),
    .last_npc_i    (last_npc),
    .seq_add_i     (nv_cnt),
    .go_o          (go),
    .pc_o          (th_pc),
    .npc_o         (th_npc),
    .seq_o         (th_seq),
    .trap_o        (trap_pend_o),
    .quiesce_o     (quiesce_pend_o)
  );

  for (genvar k = 0; k < WIDTH; k++) begin : g_seq
    assign nv_seq[k*SEQ_W +: SEQ_W] = th_seq + SEQ_W'(k);
  end

  always_comb begin
    nv_valid = '0;
    nv_fault = '0;
    nv_inst  = ch_inst;
    nv_pc    = ch_pc;
    nv_npc   = ch_npc;
    nv_cnt   = CNT_W'($countones(ch_emit));
    nv_br    = CNT_W'($countones(ch_br));
    nv_tk    = CNT_W'($countones(ch_tk));
    if (fault_i) begin
      nv_inst[INST_W-1:0] = NOP_WORD;
      nv_pc[PC_W-1:0]     = th_pc;
      nv_npc[PC_W-1:0]    = th_npc;
      nv_fault[0]         = 1'b1;
      nv_cnt              = CNT_W'(1);
      nv_br               = '0;
      nv_tk               = '0;
      nv_valid[0]         = go;
    end else begin
      nv_valid = go ? ch_emit : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_valid_o <= '0;
      slot_fault_o <= '0;
      slot_inst_o  <= '0;
      slot_pc_o    <= '0;
      slot_npc_o   <= '0;
      slot_seq_o   <= '0;
      wrote_o      <= 1'b0;
      emit_cnt_o   <= '0;
      br_cnt_o     <= '0;
      taken_cnt_o  <= '0;
    end else begin
      slot_valid_o <= nv_valid;
      slot_fault_o <= go ? nv_fault : '0;
      slot_inst_o  <= nv_inst;
      slot_pc_o    <= nv_pc;
      slot_npc_o   <= nv_npc;
      slot_seq_o   <= nv_seq;
      wrote_o      <= |nv_valid;
      emit_cnt_o   <= go ? nv_cnt : '0;
      br_cnt_o     <= go ? nv_br  : '0;
      taken_cnt_o  <= go ? nv_tk  : '0;
    end
  end

  assign pc_o  = th_pc;
  assign npc_o = th_npc;

  assert_prefix_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_o & (slot_valid_o + WIDTH'(1))) == '0);

  assert_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_cnt_o <= CNT_W'(WIDTH));

  assert_counts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_cnt_o == CNT_W'($countones(slot_valid_o))) && (wrote_o == (emit_cnt_o != '0))
    && (taken_cnt_o <= br_cnt_o));

  assert_seq_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrote_o |=> (!wrote_o ||
      slot_seq_o[SEQ_W-1:0] == $past(slot_seq_o[SEQ_W-1:0]) + SEQ_W'($past(emit_cnt_o))));

  assert_fault_alone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_fault_o[0] |-> (emit_cnt_o == CNT_W'(1) && trap_pend_o && br_cnt_o == '0));

  assert_parked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((quiesce_pend_o || trap_pend_o) && !redirect_i) |=> !wrote_o);
endmodule

// File: tb/fetch_group_extract_tb_top.sv
module fetch_group_extract_tb_top;
  localparam int W  = 4;
  localparam int LW = 8;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        redirect_i = 1'b0;
  logic [31:0] redirect_pc_i = '0, redirect_npc_i = '0;
  logic        line_valid_i = 1'b0, fault_i = 1'b0;
  logic [31:0] ln_data [LW];
  logic [31:0] ln_tgt  [LW];
  logic [LW-1:0] ctrl_flag_i = '0, quiesce_flag_i = '0, pred_taken_i = '0;
  logic [LW*32-1:0] line_data_i, pred_target_i;

  always_comb
    for (int w = 0; w < LW; w++) begin
      line_data_i[w*32 +: 32]   = ln_data[w];
      pred_target_i[w*32 +: 32] = ln_tgt[w];
    end

  logic [W-1:0]    slot_valid_o, slot_fault_o;
  logic [W*32-1:0] slot_inst_o, slot_pc_o, slot_npc_o;
  logic [W*16-1:0] slot_seq_o;
  logic            wrote_o, trap_pend_o, quiesce_pend_o;
  logic [2:0]      emit_cnt_o, br_cnt_o, taken_cnt_o;
  logic [31:0]     pc_o, npc_o;

  fetch_group_extract dut_i (
    .clk_i, .rst_ni, .redirect_i, .redirect_pc_i, .redirect_npc_i,
    .line_valid_i, .fault_i, .line_data_i, .ctrl_flag_i, .quiesce_flag_i,
    .pred_taken_i, .pred_target_i, .slot_valid_o, .slot_inst_o, .slot_pc_o,
    .slot_npc_o, .slot_seq_o, .slot_fault_o, .wrote_o, .emit_cnt_o,
    .br_cnt_o, .taken_cnt_o, .pc_o, .npc_o, .trap_pend_o, .quiesce_pend_o
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state: 0 run, 1 quiesce, 2 trap
  logic [31:0] m_pc, m_npc;
  logic [15:0] m_seq;
  int          m_mode;
  logic        e_valid [W], e_fault [W];
  logic [31:0] e_inst [W], e_pc [W], e_npc [W];
  logic [15:0] e_seq [W];
  logic        e_wrote;
  int          e_cnt, e_br, e_tk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < W; k++) begin e_valid[k] = 0; e_fault[k] = 0; end
    e_wrote = 0; e_cnt = 0; e_br = 0; e_tk = 0;
    if (redirect_i) begin
      m_pc = redirect_pc_i; m_npc = redirect_npc_i; m_mode = 0;
    end else if (line_valid_i && m_mode == 0) begin
      if (fault_i) begin
        e_valid[0] = 1; e_fault[0] = 1; e_inst[0] = NOP;
        e_pc[0] = m_pc; e_npc[0] = m_npc; e_seq[0] = m_seq;
        m_seq = m_seq + 1; m_mode = 2; e_wrote = 1; e_cnt = 1;
      end else begin
        int off = int'((m_pc >> 2) % LW);
        int n = 0;
        bit stop = 0;
        logic [31:0] cur = m_pc, cn = m_npc, np;
        while (!stop && off < LW && n < W) begin
          e_valid[n] = 1; e_inst[n] = ln_data[off]; e_pc[n] = cur;
          if (ctrl_flag_i[off]) begin
            e_br++;
            if (pred_taken_i[off]) begin np = ln_tgt[off]; e_tk++; end
            else np = cur + 4;
          end else np = cn;
          e_npc[n] = np; e_seq[n] = m_seq + 16'(n);
          stop = quiesce_flag_i[off] || (cur + 4 != cn) || (np != cn);
          if (quiesce_flag_i[off]) m_mode = 1;
          cur = np; cn = np + 4; n++; off++;
        end
        m_pc = cur; m_npc = cn; m_seq = m_seq + 16'(n);
        e_cnt = n; e_wrote = 1;
      end
    end
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    for (int k = 0; k < W; k++) begin
      chk(64'(slot_valid_o[k]), 64'(e_valid[k]), tag, $sformatf("slot%0d valid", k));
      if (e_valid[k]) begin
        chk(64'(slot_inst_o[k*32 +: 32]), 64'(e_inst[k]), "R2", $sformatf("slot%0d inst", k));
        chk(64'(slot_pc_o[k*32 +: 32]), 64'(e_pc[k]), "R2", $sformatf("slot%0d pc", k));
        chk(64'(slot_npc_o[k*32 +: 32]), 64'(e_npc[k]), "R4 R5", $sformatf("slot%0d npc", k));
        chk(64'(slot_seq_o[k*16 +: 16]), 64'(e_seq[k]), "R7", $sformatf("slot%0d seq", k));
        chk(64'(slot_fault_o[k]), 64'(e_fault[k]), "R9", $sformatf("slot%0d fault", k));
      end
    end
    chk(64'(pc_o), 64'(m_pc), "R10", "pc");
    chk(64'(npc_o), 64'(m_npc), "R10", "npc");
    chk(64'(trap_pend_o), 64'(m_mode == 2), "R9", "trap pending");
    chk(64'(quiesce_pend_o), 64'(m_mode == 1), "R8", "quiesce pending");
    chk(64'(wrote_o), 64'(e_wrote), "R11", "wrote");
    chk(64'(emit_cnt_o), 64'(e_cnt), "R11", "emit count");
    chk(64'(br_cnt_o), 64'(e_br), "R11", "branch count");
    chk(64'(taken_cnt_o), 64'(e_tk), "R11", "taken count");
  endtask

  task automatic set_line(input logic [31:0] base);
    for (int w = 0; w < LW; w++) begin
      ln_data[w] = 32'hC0DE_0000 ^ (base + 32'(w * 4));
      ln_tgt[w]  = 32'h0;
    end
    ctrl_flag_i = '0; quiesce_flag_i = '0; pred_taken_i = '0;
    line_valid_i = 1'b1; fault_i = 1'b0; redirect_i = 1'b0;
  endtask

  task automatic redirect(input logic [31:0] pc, input logic [31:0] npc, input bit lv);
    redirect_i = 1'b1; redirect_pc_i = pc; redirect_npc_i = npc; line_valid_i = lv;
    step("R12");
    redirect_i = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < LW; w++) begin ln_data[w] = '0; ln_tgt[w] = '0; end
    m_pc = 32'h1000; m_npc = 32'h1004; m_seq = '0; m_mode = 0;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(64'(slot_valid_o), 64'(0), "R1", "valid at reset");
    chk(64'(wrote_o), 64'(0), "R1", "wrote at reset");
    chk(64'(emit_cnt_o), 64'(0), "R1", "count at reset");
    chk(64'(pc_o), 64'h1000, "R1", "pc at reset");
    chk(64'(npc_o), 64'h1004, "R1", "npc at reset");
    chk(64'({trap_pend_o, quiesce_pend_o}), 64'(0), "R1", "pending at reset");
    rst_ni = 1'b1;
    step("R1");

    // R3 width limit, then R2 continuation to line end
    set_line(32'h1000);
    step("R3");
    step("R2");
    // R12 redirect with a valid line: nothing emitted
    redirect(32'h1018, 32'h101C, 1'b1);
    set_line(32'h1000);
    step("R2");            // words 6,7 only: line end

    // R6 taken branch ends the group
    redirect(32'h2000, 32'h2004, 1'b0);
    set_line(32'h2000);
    ctrl_flag_i[1] = 1'b1; pred_taken_i[1] = 1'b1; ln_tgt[1] = 32'h2400;
    step("R6");

    // R5 not-taken control, taken to pc+4, ignored taken flag on plain word
    redirect(32'h2400, 32'h2404, 1'b0);
    set_line(32'h2400);
    ctrl_flag_i[0] = 1'b1;
    ctrl_flag_i[1] = 1'b1; pred_taken_i[1] = 1'b1; ln_tgt[1] = 32'h2408;
    pred_taken_i[2] = 1'b1; ln_tgt[2] = 32'h9990;
    step("R5");

    // R4 non-sequential next-PC on a plain word ends after one slot
    redirect(32'h3000, 32'h3800, 1'b0);
    set_line(32'h3000);
    step("R4");
    set_line(32'h3800);
    step("R4");

    // R8 quiesce ends group and parks the thread
    redirect(32'h4000, 32'h4004, 1'b0);
    set_line(32'h4000);
    quiesce_flag_i[2] = 1'b1;
    step("R8");
    quiesce_flag_i = '0;
    step("R8");
    step("R8");

    // R9 fault gives a single no-op and parks the thread
    redirect(32'h5000, 32'h5004, 1'b0);
    set_line(32'h5000);
    fault_i = 1'b1;
    step("R9");
    fault_i = 1'b0;
    step("R9");

    // R2 unaligned start offset, then R7 numbering across cycles
    redirect(32'h6004, 32'h6008, 1'b0);
    set_line(32'h6000);
    step("R2");
    step("R7");
    line_valid_i = 1'b0;
    step("R11");
    set_line(32'h6000);
    ctrl_flag_i[1] = 1'b1;
    step("R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule